// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense Controller

This block watches a group of twelve general-purpose input pins and turns activity on each of them into an interrupt. Each pin has its own sense setting, built from three configuration bits:

- a level/edge selector;
- a polarity bit, where 1 means high level or rising edge and 0 means low level or falling edge;
- an any-edge override, which makes both edge directions trigger and ignores the polarity bit.

The pins first pass through a two-flop synchroniser. Each synchronised sample is compared with the one before it to find edges.

A raw status bit per pin records that the trigger condition has been met, before any masking. Edge-triggered bits are sticky until software clears them by writing a one. Level-triggered bits follow the pin level. A per-pin enable masks the raw status onto twelve individual interrupt outputs. The OR of all masked bits drives one combined interrupt line, which is registered.

Software reaches the block over a simple word-addressed register bus. Writes take effect on the clock edge. Reads return data combinationally from the current address.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, every register reads zero and `pin_irq_o` and `irq_any_o` are zero. The sense selector resets to edge mode and the enables to masked.
- R2: With sense=0 (edge), any-edge=0 and polarity=1, a low-to-high transition on a pin sets its raw status bit. A high-to-low transition does not.
- R3: With sense=0, any-edge=0 and polarity=0, a high-to-low transition sets the raw bit. A low-to-high transition does not.
- R4: With sense=0 and any-edge=1, both transition directions set the raw bit, whatever the polarity bit holds.
- R5: With sense=1 (level), the raw bit follows the pin: it is 1 while the pin equals the polarity bit and 0 otherwise. A write to the clear register has no effect on it.
- R6: An edge-triggered raw bit stays set until a 1 is written to its bit in the clear register at offset 0x1C. If a new edge is detected in the same cycle as the clear, the bit stays set.
- R7: The masked status (offset 0x18) and `pin_irq_o` both equal raw status AND enable, bit for bit.
- R8: `irq_any_o` is the OR of the masked status bits, delayed by one clock.
- R9: Register map, by byte offset:

  | Offset | Register | Access |
  |---|---|---|
  | 0x04 | sense | read/write |
  | 0x08 | any-edge | read/write |
  | 0x0C | polarity | read/write |
  | 0x10 | enable | read/write |
  | 0x14 | raw status | read-only |
  | 0x18 | masked status | read-only |
  | 0x1C | clear | write-only, reads zero |

  Pin k uses bit k. Bits 31:12 read zero and ignore writes. Unmapped offsets read zero. Writes to 0x14 and 0x18 are ignored.
- R10: A pin change made between two clock edges appears in the raw status after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 12 | Asynchronous pin inputs |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_irq_o | output | 12 | Per-pin masked interrupts |
| irq_any_o | output | 1 | Registered OR of all masked interrupts |

## Verification
The assertions check the status update rule on every cycle:

- a detected edge always leaves its bit set, even when a clear lands in the same cycle;
- a level-mode bit always matches the previous cycle's level condition;
- an edge-mode bit never rises without an edge;
- a clear with no competing edge always drops the bit;
- the combined line rises only after some masked bit was set.

Only the bench's scenarios can show the rest:

- the exact synchroniser latency;
- the decode of each polarity and any-edge combination from real pin waveforms;
- the register map, including reserved bits, ignored writes and unmapped reads.

A cycle-level reference model checks random pins, configurations and clears against all outputs.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

  // byte offsets of the register map
  localparam logic [7:0] OFS_SENSE  = 8'h04;
  localparam logic [7:0] OFS_BOTH   = 8'h08;
  localparam logic [7:0] OFS_POL    = 8'h0C;
  localparam logic [7:0] OFS_ENABLE = 8'h10;
  localparam logic [7:0] OFS_RAW    = 8'h14;
  localparam logic [7:0] OFS_MASKED = 8'h18;
  localparam logic [7:0] OFS_CLEAR  = 8'h1C;

  // trigger condition of one pin for the current cycle
  function automatic logic pin_hit(input logic cur, input logic prev,
                                   input logic lvl, input logic both,
                                   input logic pol);
    logic changed;
    logic pol_ok;
    changed = cur ^ prev;
    pol_ok  = (cur == pol);
    if (lvl) pin_hit = pol_ok;
    else     pin_hit = changed & (both | pol_ok);
  endfunction

  // next status bit given the current one, trigger, mode and clear request
  function automatic logic next_status(input logic st, input logic hit,
                                       input logic lvl, input logic clr);
    if (lvl) next_status = hit;
    else     next_status = (st & ~clr) | hit;
  endfunction

endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
  parameter int N      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/gpirq_detect.sv
module gpirq_detect #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] both_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] hit_o,
  output logic [N-1:0] status_o
);

  logic [N-1:0] prev_q;
  logic [N-1:0] status_q;
  logic [N-1:0] hit;
  logic [N-1:0] edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign hit[i] = gpirq_pkg::pin_hit(cur_i[i], prev_q[i], lvl_i[i],
                                       both_i[i], pol_i[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= gpirq_pkg::next_status(status_q[i], hit[i],
                                                        lvl_i[i], clr_i[i]);
    end
  end

  assign edge_hit = hit & ~lvl_i;
  assign hit_o    = hit;
  assign status_o = status_q;

  // R6
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(edge_hit)) == $past(edge_hit)));

  // R6
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_i & ~hit & ~lvl_i)) == '0));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & $past(~hit & ~lvl_i)) == '0));

  // R5
  level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status_q ^ $past(hit)) & $past(lvl_i)) == '0));

endmodule

// File: rtl/gpirq_regs.sv
module gpirq_regs #(
  parameter int N      = 12,
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [N-1:0]      status_i,
  output logic [N-1:0]      lvl_o,
  output logic [N-1:0]      both_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      clr_o,
  output logic [N-1:0]      masked_o,
  output logic [DW-1:0]     rdata_o
);

  localparam int WA = ADDR_W - 2;
  localparam logic [WA-1:0] W_SENSE  = WA'(gpirq_pkg::OFS_SENSE  >> 2);
  localparam logic [WA-1:0] W_BOTH   = WA'(gpirq_pkg::OFS_BOTH   >> 2);
  localparam logic [WA-1:0] W_POL    = WA'(gpirq_pkg::OFS_POL    >> 2);
  localparam logic [WA-1:0] W_ENABLE = WA'(gpirq_pkg::OFS_ENABLE >> 2);
  localparam logic [WA-1:0] W_RAW    = WA'(gpirq_pkg::OFS_RAW    >> 2);
  localparam logic [WA-1:0] W_MASKED = WA'(gpirq_pkg::OFS_MASKED >> 2);
  localparam logic [WA-1:0] W_CLEAR  = WA'(gpirq_pkg::OFS_CLEAR  >> 2);

  logic [WA-1:0] widx;
  logic [N-1:0]  wbits;
  logic [N-1:0]  lvl_q, both_q, pol_q, en_q;
  logic [N-1:0]  rsel;
  logic          unused_bits;

  assign widx        = addr_i[ADDR_W-1:2];
  assign wbits       = wdata_i[N-1:0];
  assign unused_bits = ^{addr_i[1:0], wdata_i[DW-1:N]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      both_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else if (wr_i) begin
      if (widx == W_SENSE)  lvl_q  <= wbits;
      if (widx == W_BOTH)   both_q <= wbits;
      if (widx == W_POL)    pol_q  <= wbits;
      if (widx == W_ENABLE) en_q   <= wbits;
    end
  end

  assign clr_o    = (wr_i && widx == W_CLEAR) ? wbits : '0;
  assign masked_o = status_i & en_q;

  always_comb begin
    case (widx)
      W_SENSE:  rsel = lvl_q;
      W_BOTH:   rsel = both_q;
      W_POL:    rsel = pol_q;
      W_ENABLE: rsel = en_q;
      W_RAW:    rsel = status_i;
      W_MASKED: rsel = masked_o;
      default:  rsel = '0;
    endcase
  end

  assign rdata_o = {{(DW-N){1'b0}}, rsel};
  assign lvl_o   = lvl_q;
  assign both_o  = both_q;
  assign pol_o   = pol_q;
  assign en_o    = en_q;

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int N      = 12,
  parameter int DW     = 32,
  parameter int ADDR_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      pin_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [N-1:0]      pin_irq_o,
  output logic              irq_any_o
);

  logic [N-1:0] pin_sync;
  logic [N-1:0] lvl, both, pol, en, clr;
  logic [N-1:0] hit, status, masked;
  logic         any_q;

  gpirq_sync #(.N(N), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
  );

  gpirq_detect #(.N(N)) u_detect (
    .clk(clk), .rst_n(rst_n), .cur_i(pin_sync), .lvl_i(lvl),
    .both_i(both), .pol_i(pol), .clr_i(clr), .hit_o(hit),
    .status_o(status)
  );

  gpirq_regs #(.N(N), .DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .status_i(status), .lvl_o(lvl), .both_o(both),
    .pol_o(pol), .en_o(en), .clr_o(clr), .masked_o(masked),
    .rdata_o(bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_q <= 1'b0;
    else        any_q <= |masked;
  end

  assign pin_irq_o = masked;
  assign irq_any_o = any_q;

  logic unused_hit;
  assign unused_hit = ^hit;

  // R8
  any_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_q) |-> $past(|masked));

  // R7
  masked_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_irq_o & ~en) == '0);

endmodule

// File: tb/gpio_irq_sense_bench.sv
`timescale 1ns/1ps
module gpio_irq_sense_bench;

  localparam int N = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pin_irq;
  logic        irq_any;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_sense u_gpio_irq_sense (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_irq_o(pin_irq), .irq_any_o(irq_any)
  );

  // ---------------- reference model ----------------
  logic [N-1:0] m_s1, m_s2, m_prev, m_st, m_lvl, m_both, m_pol, m_en;
  logic         m_any;

  function automatic logic [N-1:0] model_hit(input logic [N-1:0] c,
      input logic [N-1:0] p, input logic [N-1:0] lv, input logic [N-1:0] bo,
      input logic [N-1:0] po);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      case ({lv[i], bo[i], po[i]})
        3'b100:  r[i] = !c[i];
        3'b101:  r[i] = c[i];
        3'b110:  r[i] = !c[i];
        3'b111:  r[i] = c[i];
        3'b010,
        3'b011:  r[i] = (c[i] != p[i]);
        3'b001:  r[i] = c[i] && !p[i];
        default: r[i] = !c[i] && p[i];
      endcase
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_st <= '0;
      m_lvl <= '0; m_both <= '0; m_pol <= '0; m_en <= '0; m_any <= 1'b0;
    end else begin
      logic [N-1:0] h, c;
      h = model_hit(m_s2, m_prev, m_lvl, m_both, m_pol);
      c = (bus_wr && bus_addr == 8'h1C) ? bus_wdata[N-1:0] : '0;
      m_st   <= (m_lvl & h) | (~m_lvl & ((m_st & ~c) | h));
      m_any  <= |(m_st & m_en);
      m_s1   <= pins;
      m_s2   <= m_s1;
      m_prev <= m_s2;
      if (bus_wr) begin
        if (bus_addr == 8'h04) m_lvl  <= bus_wdata[N-1:0];
        if (bus_addr == 8'h08) m_both <= bus_wdata[N-1:0];
        if (bus_addr == 8'h0C) m_pol  <= bus_wdata[N-1:0];
        if (bus_addr == 8'h10) m_en   <= bus_wdata[N-1:0];
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=0x0 exp=0x1");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    ticks(3);
    rst_n = 1'b1;
    ticks(2);

    // R1 reset values
    for (int a = 4; a <= 28; a += 4) begin
      rd(8'(a), d);
      check("R1 reg reset", d, 32'h0);
    end
    check("R1 pin_irq reset", 32'(pin_irq), 32'h0);
    check("R1 irq_any reset", 32'(irq_any), 32'h0);

    // R9 map details
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R9 reserved bits", d, 32'h0000_0FFF);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); check("R9 raw write ignored", d, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, d); check("R9 masked write ignored", d, 32'h0);
    rd(8'h20, d); check("R9 unmapped read", d, 32'h0);
    rd(8'h00, d); check("R9 unmapped low read", d, 32'h0);
    wr(8'h1C, 32'hFFF);
    rd(8'h1C, d); check("R9 clear reads zero", d, 32'h0);

    // configure: pin0 rising, pin1 falling, pin2 any-edge, 3/4 level
    wr(8'h0C, 32'h009);           // pol: pin0=1, pin3=1, others 0
    wr(8'h08, 32'h004);           // any-edge on pin2
    wr(8'h04, 32'h018);           // level on pins 3 and 4
    // pin4 is low-level with pin low -> raw sets
    ticks(1);
    rd(8'h14, d); check("R5 low level sets", d & 32'h18, 32'h10);
    wr(8'h10, 32'h0);             // mask all
    ticks(1);

    // R10 / R2 rising on pin0
    wr(8'h10, 32'hFFF);
    wr(8'h1C, 32'hFFF);
    ticks(2);
    pins[0] = 1'b1;
    ticks(2);
    rd(8'h14, d); check("R10 not after two edges", d & 32'h1, 32'h0);
    ticks(1);
    rd(8'h14, d); check("R10/R2 set after three edges", d & 32'h1, 32'h1);
    check("R7 pin_irq bit0", 32'(pin_irq[0]), 32'h1);
    check("R8 irq_any lag", 32'(irq_any), 32'h1);  // pin4 already active
    ticks(10);
    rd(8'h14, d); check("R6 sticky", d & 32'h1, 32'h1);
    wr(8'h1C, 32'h1);
    rd(8'h14, d); check("R6 clear", d & 32'h1, 32'h0);
    pins[0] = 1'b0;
    ticks(5);
    rd(8'h14, d); check("R2 falling ignored", d & 32'h1, 32'h0);

    // R3 falling on pin1
    pins[1] = 1'b1; ticks(5);
    rd(8'h14, d); check("R3 rising ignored", d & 32'h2, 32'h0);
    pins[1] = 1'b0; ticks(5);
    rd(8'h14, d); check("R3 falling sets", d & 32'h2, 32'h2);

    // R4 any-edge on pin2
    pins[2] = 1'b1; ticks(5);
    rd(8'h14, d); check("R4 rise", d & 32'h4, 32'h4);
    wr(8'h1C, 32'h4);
    pins[2] = 1'b0; ticks(5);
    rd(8'h14, d); check("R4 fall", d & 32'h4, 32'h4);

    // R5 level high on pin3, clear no effect, release
    pins[3] = 1'b1; ticks(4);
    rd(8'h14, d); check("R5 high level", d & 32'h8, 32'h8);
    wr(8'h1C, 32'h8);
    rd(8'h14, d); check("R5 clear no effect", d & 32'h8, 32'h8);
    pins[3] = 1'b0; ticks(4);
    rd(8'h14, d); check("R5 follows low", d & 32'h8, 32'h0);

    // R6 edge wins over same-cycle clear, pin5 rising (pol bit5 = 0 -> set it)
    wr(8'h0C, 32'h029);
    ticks(1);
    pins[5] = 1'b1;
    ticks(2);
    wr(8'h1C, 32'h20);
    rd(8'h14, d); check("R6 edge wins", d & 32'h20, 32'h20);
    wr(8'h1C, 32'h20);
    rd(8'h14, d); check("R6 clear after win", d & 32'h20, 32'h0);

    // R7 / R8 masking
    pins[5] = 1'b0;
    wr(8'h10, 32'h0);
    ticks(2);
    check("R8 any low when masked", 32'(irq_any), 32'h0);
    wr(8'h10, 32'h010);
    rd(8'h18, d); check("R7 masked read", d, 32'h010);
    check("R7 pin_irq", 32'(pin_irq), 32'h010);
    check("R8 any before lag", 32'(irq_any), 32'h0);
    ticks(1);
    check("R8 any after lag", 32'(irq_any), 32'h1);

    // random phase against model
    for (int k = 0; k < 600; k++) begin
      pins = pins ^ (N'($urandom) & N'($urandom) & N'($urandom));
      if (($urandom % 6) == 0) begin
        case ($urandom % 5)
          0: wr(8'h04, $urandom);
          1: wr(8'h08, $urandom);
          2: wr(8'h0C, $urandom);
          3: wr(8'h10, $urandom);
          default: wr(8'h1C, $urandom);
        endcase
      end else begin
        ticks(1);
      end
      rd(8'h14, d); check("R2-model raw", d, 32'(m_st));
      check("R7 model pin_irq", 32'(pin_irq), 32'(m_st & m_en));
      check("R8 model irq_any", 32'(irq_any), 32'(m_any));
    end

    done = 1;
    summary();
    $finish;
  end

endmodule